// File: doc/BRIEF.md
# Masked Port Transition Detector

The block watches a group of seven general-purpose input ports for changes of logic level and raises one sticky interrupt flag when any of the ports selected by a 7-bit enable mask changes. The raw port levels cross into the clock domain through a two-flop synchronizer. The block compares the synchronized levels against a snapshot that is taken every time software reads the mask/status register. The flag does not say which port changed. Software reads the register to learn that something moved, and that read clears the flag and takes a new snapshot.

The highest port of the bank (the eighth, next to the seven watched ones) can carry the flag out of the chip. When its two-bit configuration selects output mode, that pin drives the flag active-high. In any other mode the interrupt pin value is held low.

Top module: `chg_watch`

## Requirements
- R1: After reset the flag is 0, the mask is 0, the read word is 0x00 and the interrupt pin value is 0.
- R2: A mask write (`mask_wr_i` high for one cycle) makes read-word bits 6..0 equal to the written value from the next cycle on.
- R3: A level change on an enabled port, in either direction, is seen on `flag_o` exactly three rising clock edges after it appears at `port_lvl_i`, and not earlier.
- R4: A port whose mask bit is 0 never sets the flag, however it toggles.
- R5: Once set, the flag stays set until a read, even when the port returns to its snapshot level.
- R6: The read word is {flag in bit 7, mask in bits 6..0}. It is valid in the cycle `mask_rd_i` is high, and the flag is cleared at the end of that cycle.
- R7: A read stores the synchronized port levels as the new snapshot. Later levels equal to that snapshot do not set the flag, and levels that differ from it do.
- R8: If an enabled port differs from the snapshot during the read cycle, the flag is 1 after the read, so that change is not lost.
- R9: The interrupt pin value equals the flag when the port configuration is 2'b01 (output). It is 0 for the configurations 2'b00, 2'b10 and 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_lvl_i | input | 7 | Raw levels of the seven watched ports |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 7 | Mask value to write, bit n enables port n |
| mask_rd_i | input | 1 | Mask/status read strobe |
| int_port_cfg_i | input | 2 | Mode bit pair of the interrupt-capable port, 2'b01 = output |
| rdata_o | output | 8 | Read word: flag in bit 7, mask in bits 6..0 |
| flag_o | output | 1 | Sticky change flag |
| int_pin_o | output | 1 | Value driven on the interrupt-capable port |

## Verification
On every cycle the assertions check that the flag stays sticky between reads, that a read clears the flag unless a pending enabled difference exists (and keeps it when one does), that the snapshot equals the levels present at the read, that an all-zero mask keeps the flag clear, and that the interrupt pin only ever shows the flag. The bench scenarios show the exact three-edge latency and the mask-by-port sweep of which toggles count. They also show the read word contents and the behaviour when a port returns to its old level. These depend on stimulus history, which a single-cycle property cannot see.

// File: rtl/chg_watch_pkg.sv
package chg_watch_pkg;
  // Mode bit pair of a port
  typedef enum logic [1:0] {
    PCFG_RSVD  = 2'b00,
    PCFG_OUT   = 2'b01,
    PCFG_IN    = 2'b10,
    PCFG_IN_PU = 2'b11
  } pcfg_e;
endpackage

// File: rtl/chg_watch_sync.sv
module chg_watch_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/chg_watch_cmp.sv
module chg_watch_cmp #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] mask,
  input  logic         take,
  output logic [W-1:0] snap,
  output logic         hit
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (take) begin
      snap_d = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else begin
      snap_q <= snap_d;
    end
  end

  assign hit  = |((lvl ^ snap_q) & mask);
  assign snap = snap_q;
endmodule

// File: rtl/chg_watch_flag.sv
module chg_watch_flag #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         hit,
  output logic [W-1:0] mask,
  output logic         flag
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         flag_q;
  logic         flag_d;

  always_comb begin
    mask_d = mask_q;
    if (wr) begin
      mask_d = wdata;
    end
    // a difference present in the read cycle re-arms the flag
    flag_d = hit | (flag_q & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign mask = mask_q;
  assign flag = flag_q;
endmodule

// File: rtl/chg_watch.sv
module chg_watch #(
  parameter int NPORT       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_lvl_i,
  input  logic             mask_wr_i,
  input  logic [NPORT-1:0] mask_wdata_i,
  input  logic             mask_rd_i,
  input  logic [1:0]       int_port_cfg_i,
  output logic [NPORT:0]   rdata_o,
  output logic             flag_o,
  output logic             int_pin_o
);
  import chg_watch_pkg::*;

  logic             rst_s;
  logic [NPORT-1:0] lvl_s;
  logic [NPORT-1:0] snap_s;
  logic [NPORT-1:0] mask_s;
  logic             hit_s;
  logic             flag_s;
  logic             int_en;

  chg_watch_sync #(.W(1), .STAGES(RST_STAGES)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_s)
  );

  chg_watch_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk  (clk),
    .rst_n(rst_s),
    .din  (port_lvl_i),
    .dout (lvl_s)
  );

  chg_watch_cmp #(.W(NPORT)) u_cmp (
    .clk  (clk),
    .rst_n(rst_s),
    .lvl  (lvl_s),
    .mask (mask_s),
    .take (mask_rd_i),
    .snap (snap_s),
    .hit  (hit_s)
  );

  chg_watch_flag #(.W(NPORT)) u_flag (
    .clk  (clk),
    .rst_n(rst_s),
    .wr   (mask_wr_i),
    .wdata(mask_wdata_i),
    .rd   (mask_rd_i),
    .hit  (hit_s),
    .mask (mask_s),
    .flag (flag_s)
  );

  assign int_en    = (pcfg_e'(int_port_cfg_i) == PCFG_OUT);
  assign int_pin_o = flag_s & int_en;
  assign flag_o    = flag_s;
  assign rdata_o   = {flag_s, mask_s};
endmodule

// File: rtl/chg_watch_chk.sv
module chg_watch_chk #(
  parameter int NPORT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_wr,
  input logic [NPORT-1:0] mask_wdata,
  input logic             mask_rd,
  input logic [1:0]       cfg,
  input logic [NPORT:0]   rdata,
  input logic             flag,
  input logic             int_pin,
  input logic [NPORT-1:0] lvl,
  input logic [NPORT-1:0] snap
);
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> rdata[NPORT-1:0] == $past(mask_wdata));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && rdata[NPORT-1:0] == '0) |=> !flag);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mask_rd) |=> flag);

  p_flag_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[NPORT] == flag);

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && ((lvl ^ snap) & rdata[NPORT-1:0]) == '0) |=> !flag);

  p_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd |=> snap == $past(lvl));

  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rd && ((lvl ^ snap) & rdata[NPORT-1:0]) != '0) |=> flag);

  p_int_only_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_pin |-> (flag && cfg == 2'b01));
endmodule

bind chg_watch chg_watch_chk #(.NPORT(NPORT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .mask_wr   (mask_wr_i),
  .mask_wdata(mask_wdata_i),
  .mask_rd   (mask_rd_i),
  .cfg       (int_port_cfg_i),
  .rdata     (rdata_o),
  .flag      (flag_o),
  .int_pin   (int_pin_o),
  .lvl       (lvl_s),
  .snap      (snap_s)
);

// File: tb/chg_watch_tb.sv
module chg_watch_tb_top;
  logic       clk;
  logic       rst_n;
  logic [6:0] lvl;
  logic       wr;
  logic [6:0] wdata;
  logic       rd;
  logic [1:0] cfg;
  logic [7:0] rdata;
  logic       flag;
  logic       intp;
  int         checks;
  int         errors;

  chg_watch dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_lvl_i    (lvl),
    .mask_wr_i     (wr),
    .mask_wdata_i  (wdata),
    .mask_rd_i     (rd),
    .int_port_cfg_i(cfg),
    .rdata_o       (rdata),
    .flag_o        (flag),
    .int_pin_o     (intp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", rq, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [6:0] m);
    wr = 1'b1;
    wdata = m;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd = 1'b1;
    #1 v = rdata;
    cyc(1);
    rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    lvl = 7'h7F;
    wr = 1'b0;
    wdata = '0;
    rd = 1'b0;
    cfg = 2'b01;
    cyc(3);
    lvl = 7'h00;
    rst_n = 1'b1;
    cyc(5);

    // R1: reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 flag", flag, 0);
    chk("R1 int", intp, 0);

    // R2: mask write visible
    do_write(7'h55);
    chk("R2 mask 55", rdata[6:0], 7'h55);
    do_write(7'h2A);
    chk("R2 mask 2A", rdata[6:0], 7'h2A);
    do_read(v);
    cfg = 2'b00;

    // R3 R4 R6: sweep every mask against every port
    for (int m = 0; m < 128; m++) begin
      for (int p = 0; p < 7; p++) begin
        do_write(m[6:0]);
        do_read(v);
        lvl[p] = ~lvl[p];
        cyc(2);
        chk("R3 latency not early", flag, 0);
        cyc(1);
        if (m[p]) chk("R3 enabled change sets flag", flag, 1);
        else      chk("R4 masked port ignored", flag, 0);
        do_read(v);
        chk("R6 read word", v, {m[p] ? 1'b1 : 1'b0, m[6:0]});
        do_read(v);
        chk("R6 read clears", flag, 0);
      end
    end

    // R5: sticky after return to snapshot level
    do_write(7'h7F);
    do_read(v);
    lvl[0] = ~lvl[0];
    cyc(3);
    lvl[0] = ~lvl[0];
    cyc(6);
    chk("R5 sticky flag", flag, 1);
    do_read(v);
    chk("R5 read shows flag", v, 8'hFF);
    cyc(1);
    chk("R6 flag cleared", flag, 0);

    // R7: levels equal to snapshot stay quiet, later change flags
    cyc(5);
    chk("R7 quiet after read", flag, 0);
    lvl[5] = ~lvl[5];
    cyc(3);
    chk("R7 differ from snapshot", flag, 1);
    do_read(v);
    do_read(v);
    chk("R7 cleared", flag, 0);

    // R8: change pending in the read cycle
    lvl[3] = ~lvl[3];
    cyc(2);
    do_read(v);
    chk("R8 read before flag", v[7], 0);
    chk("R8 flag kept", flag, 1);
    do_read(v);
    chk("R8 second read word", v, 8'hFF);
    chk("R8 then clear", flag, 0);

    // R9: interrupt pin gating
    lvl[1] = ~lvl[1];
    cyc(3);
    for (int c = 0; c < 4; c++) begin
      cfg = c[1:0];
      #1;
      chk("R9 int with flag", intp, (c == 1) ? 1 : 0);
    end
    do_read(v);
    do_read(v);
    cfg = 2'b01;
    #1;
    chk("R9 int without flag", intp, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule